// File: doc/BRIEF.md
# Serial Status Readout Sequencer

This controller fetches a 16-bit status word from an external parallel-in, serial-out register pair. That register pair holds two storage levels: a holding latch and a shift stage. A host asks for a read with a one-cycle start request. The controller first gives the latch a capture strobe, which snapshots the status inputs. It then drives the load-mode line low for a host-chosen number of cycles, so that the latched word moves into the shift stage. Next it releases that line, asserts the active-low select, and produces sixteen shift clocks. During those clocks it gathers the serial data into a parallel result.

The host sees a busy flag, a one-cycle done pulse and the assembled word. In continuous mode the controller issues the capture strobe for the following word while the current word is still shifting. When the current word ends, the controller goes straight to the transfer step for that next word and does not capture again. This lets reads follow each other with only the load and setup cycles between them.

Top module: `status_readout_seq`

## Requirements
- R1: After reset, busy and done are 0, the select line sel_n and the load-mode line xfer_n are 1, and the shift clock sclk and the capture strobe snap_strb are 0.
- R2: A start request taken while idle makes snap_strb high for exactly one cycle, in the first cycle after the request. xfer_n goes low in the following cycle.
- R3: xfer_n stays low for load_cycles consecutive cycles, with a value of 0 treated as 1. It is high in every cycle in which sclk is high.
- R4: sel_n is 0 (selected) whenever sclk is high. It is 1 whenever the controller is idle.
- R5: Each word is read with exactly 16 rising edges of sclk.
- R6: Serial data is sampled on each falling edge of sclk. The first sample is bit 15 of rd_word and the last sample is bit 0. rd_word changes only in a cycle in which done is high.
- R7: sclk idles low. Its period is 2*SCLK_HALF system clocks, which is 4 with the default setting.
- R8: done is a single-cycle pulse that comes with the new rd_word. busy rises in the cycle after an accepted start, stays high until the final done, and is low in that done cycle.
- R9: A start request that arrives while busy has no effect: it produces no extra capture strobe, no extra done and no change to the word being read.
- R10: If cont_mode is 1 at the first falling edge of a word, a one-cycle capture strobe follows that edge. After the word, the captured next word is loaded and read with no further capture strobe. If cont_mode is 0 at that edge, the run stops after the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-cycle read request from the host |
| cont_mode | input | 1 | Keep reading back-to-back words while 1 |
| load_cycles | input | LOAD_W | Cycles to hold the load-mode line low (0 means 1) |
| busy | output | 1 | Read sequence in progress |
| done | output | 1 | One-cycle pulse: rd_word holds a new word |
| rd_word | output | WORD_W | Last assembled status word |
| snap_strb | output | 1 | Capture strobe; its rising edge latches the status inputs |
| xfer_n | output | 1 | Load-mode line; low moves the latch into the shift stage |
| sel_n | output | 1 | Active-low select that enables the serial output |
| sclk | output | 1 | Generated shift clock |
| sdi | input | 1 | Serial data from the shift stage |

## Verification
Two functions can fall in the same cycle in continuous mode. One is the capture strobe for the next word. The other is the falling-edge sample of the current word, and the strobe comes right after the first such sample. The bench changes the external status value after each capture strobe it sees. It then checks two things: the first word returned is the value present at the start, and the second word is the value present at the mid-shift strobe. Both must be intact, which shows that the capture did not disturb the shifting. A start request raised during shifting also meets the active sequence, and it is judged by counting capture strobes and done pulses.

// File: rtl/srs_pkg.sv
// Package: shared state encoding of the status readout sequencer.
// Assumes: one sequencer state register per instance.
package srs_pkg;

    // Phases of one read: capture, transfer, select setup, shift.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CAPT  = 3'd1,
        ST_LOAD  = 3'd2,
        ST_SETUP = 3'd3,
        ST_SHIFT = 3'd4
    } rd_state_t;

endpackage

// File: rtl/srs_sclk_gen.sv
// Module: shift clock generator.
// Produces a low-idle shift clock with a period of 2*SCLK_HALF system
// clocks while enabled. It flags the system-clock edge on which the
// shift clock falls.
// Assumes: SCLK_HALF >= 1; en is a registered, glitch-free level.
module srs_sclk_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic fall_tick
);
    localparam int CNT_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SCLK_HALF - 1);

    logic [CNT_W-1:0] half_cnt;
    logic             sclk_q;

    // Count half-periods and toggle the clock at each wrap; park low when off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            half_cnt <= '0;
            sclk_q   <= 1'b0;
        end else if (half_cnt == CNT_TOP) begin
            half_cnt <= '0;
            sclk_q   <= ~sclk_q;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    // The high-to-low transition happens on this edge.
    always_comb fall_tick = en && sclk_q && (half_cnt == CNT_TOP);

    assign sclk = sclk_q;
endmodule

// File: rtl/srs_collect.sv
// Module: serial collector.
// Shifts the serial input in, MSB first, on every falling-edge tick. At the
// final tick it publishes the full word and raises a one-cycle done flag.
// Assumes: last_bit only coincides with fall_tick.
module srs_collect #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_tick,
    input  logic              last_bit,
    input  logic              sdi,
    output logic [WORD_W-1:0] rd_word,
    output logic              done
);
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_nx;

    // Next accumulator value with the current serial bit appended.
    always_comb acc_nx = {acc_q[WORD_W-2:0], sdi};

    // Accumulate bits and publish the completed word together with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            rd_word <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (fall_tick) begin
                acc_q <= acc_nx;
                if (last_bit) begin
                    rd_word <= acc_nx;
                    done    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/srs_fsm.sv
// Module: readout sequencer.
// Orders the capture strobe, the load-mode window, the select setup and the
// shift phase. It counts shifted bits and arranges the next-word capture
// in continuous mode.
// Assumes: fall_tick comes from a generator enabled by sclk_en.
module srs_fsm
    import srs_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LOAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              cont_mode,
    input  logic [LOAD_W-1:0] load_cycles,
    input  logic              fall_tick,
    output logic              busy,
    output logic              snap_strb,
    output logic              xfer_n,
    output logic              sel_n,
    output logic              sclk_en,
    output logic              last_bit
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    rd_state_t         state;
    logic [LOAD_W-1:0] ld_cnt;
    logic [LOAD_W-1:0] ld_len;
    logic [BIT_W-1:0]  bit_cnt;
    logic              busy_q;
    logic              mid_cap_q;
    logic              chain_q;
    logic              first_fall;

    // Effective load window: a zero request still gets one cycle.
    always_comb ld_len = (load_cycles == '0) ? LOAD_W'(1) : load_cycles;

    // Falling-edge tick for the first and the last bit of the current word.
    always_comb begin
        first_fall = (state == ST_SHIFT) && fall_tick && (bit_cnt == '0);
        last_bit   = (state == ST_SHIFT) && fall_tick && (bit_cnt == BIT_LAST);
    end

    // Walk through the read phases and count load cycles and shifted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ld_cnt    <= '0;
            bit_cnt   <= '0;
            busy_q    <= 1'b0;
            mid_cap_q <= 1'b0;
            chain_q   <= 1'b0;
        end else begin
            mid_cap_q <= first_fall && cont_mode;
            unique case (state)
                ST_IDLE: begin
                    if (req_start) begin
                        state   <= ST_CAPT;
                        busy_q  <= 1'b1;
                        chain_q <= 1'b0;
                    end
                end
                ST_CAPT: begin
                    state  <= ST_LOAD;
                    ld_cnt <= LOAD_W'(1);
                end
                ST_LOAD: begin
                    if (ld_cnt >= ld_len) begin
                        state <= ST_SETUP;
                    end else begin
                        ld_cnt <= ld_cnt + 1'b1;
                    end
                end
                ST_SETUP: begin
                    state   <= ST_SHIFT;
                    bit_cnt <= '0;
                end
                ST_SHIFT: begin
                    if (fall_tick) begin
                        if (bit_cnt == BIT_LAST) begin
                            bit_cnt <= '0;
                            if (chain_q) begin
                                state   <= ST_LOAD;
                                ld_cnt  <= LOAD_W'(1);
                                chain_q <= 1'b0;
                            end else begin
                                state  <= ST_IDLE;
                                busy_q <= 1'b0;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == '0) begin
                                chain_q <= cont_mode;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the external strobes from the registered phase.
    always_comb begin
        snap_strb = (state == ST_CAPT) || mid_cap_q;
        xfer_n    = (state != ST_LOAD);
        sel_n     = !((state == ST_SETUP) || (state == ST_SHIFT));
        sclk_en   = (state == ST_SHIFT);
        busy      = busy_q;
    end
endmodule

// File: rtl/status_readout_seq.sv
// Module: serial status readout sequencer (top).
// Reads one status word (or back-to-back words) from an external
// latch-plus-shift register pair over a select/clock/data link.
// Assumes: the external register shifts its next bit out after each falling
// edge of sclk and drives sdi only while sel_n is low.
module status_readout_seq #(
    parameter int WORD_W    = 16,
    parameter int LOAD_W    = 4,
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              cont_mode,
    input  logic [LOAD_W-1:0] load_cycles,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_word,
    output logic              snap_strb,
    output logic              xfer_n,
    output logic              sel_n,
    output logic              sclk,
    input  logic              sdi
);
    logic sclk_en;
    logic fall_tick;
    logic last_bit;

    // Phase sequencing and strobe generation.
    srs_fsm #(.WORD_W(WORD_W), .LOAD_W(LOAD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_start(req_start),
        .cont_mode(cont_mode), .load_cycles(load_cycles),
        .fall_tick(fall_tick), .busy(busy), .snap_strb(snap_strb),
        .xfer_n(xfer_n), .sel_n(sel_n), .sclk_en(sclk_en),
        .last_bit(last_bit)
    );

    // Divided shift clock.
    srs_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
        .clk(clk), .rst_n(rst_n), .en(sclk_en),
        .sclk(sclk), .fall_tick(fall_tick)
    );

    // Serial-to-parallel assembly.
    srs_collect #(.WORD_W(WORD_W)) u_col (
        .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick),
        .last_bit(last_bit), .sdi(sdi), .rd_word(rd_word), .done(done)
    );
endmodule

// File: rtl/srs_checker.sv
// Module: property checker for the readout sequencer, bound to the top.
// Assumes: only top-level ports are observed.
module srs_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] rd_word,
    input logic              snap_strb,
    input logic              xfer_n,
    input logic              sel_n,
    input logic              sclk
);
    localparam int RC_W = $clog2(WORD_W) + 2;

    logic            sclk_d;
    logic [RC_W-1:0] rise_cnt;

    // Count sclk rising edges since the last load window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            if (!xfer_n) begin
                rise_cnt <= '0;
            end else if (sclk && !sclk_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    p_cap_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (snap_strb && $past(req_start)));
    p_cap_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        snap_strb |=> !snap_strb);
    p_load_no_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (xfer_n && $past(xfer_n)));
    p_sel_during_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !sel_n);
    p_sel_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> sel_n);
    p_sixteen_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rise_cnt == RC_W'(WORD_W)));
    p_word_only_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_word) |-> done);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_low_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind status_readout_seq srs_checker #(.WORD_W(WORD_W)) u_srs_chk (.*);

// File: tb/test_status_readout_seq.sv
// Bench: directed scenarios for the status readout sequencer, with a
// behavioural latch-plus-shift register model on the serial link.
module test_status_readout_seq;
    localparam int WORD_W = 16;
    localparam int LOAD_W = 4;
    localparam int HALF   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_start = 1'b0;
    logic              cont_mode = 1'b0;
    logic [LOAD_W-1:0] load_cycles = 4'd2;
    logic              busy, done, snap_strb, xfer_n, sel_n, sclk;
    logic [WORD_W-1:0] rd_word;
    logic              sdi;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    status_readout_seq #(.WORD_W(WORD_W), .LOAD_W(LOAD_W), .SCLK_HALF(HALF))
    i_status_readout_seq (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .cont_mode(cont_mode),
        .load_cycles(load_cycles), .busy(busy), .done(done), .rd_word(rd_word),
        .snap_strb(snap_strb), .xfer_n(xfer_n), .sel_n(sel_n), .sclk(sclk),
        .sdi(sdi)
    );

    // External register model: latch on the capture edge, load while the
    // load line is low, advance after each falling sclk edge.
    logic [WORD_W-1:0] status_in = '0;
    logic [WORD_W-1:0] latch_q = '0;
    logic [WORD_W-1:0] sr_q = '0;
    always @(posedge snap_strb) latch_q = status_in;
    always @(negedge clk) if (!xfer_n) sr_q = latch_q;
    always @(negedge sclk) if (xfer_n) sr_q = {sr_q[WORD_W-2:0], 1'b1};
    assign sdi = sel_n ? 1'bz : sr_q[WORD_W-1];

    // Port monitors, sampled away from the active edge.
    int cyc = 0, rise_cnt = 0, cap_cnt = 0, done_cnt = 0;
    int lo_run = 0, lo_last = 0, last_rise = 0, period = 0;
    logic sclk_p = 1'b0, cap_p = 1'b0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sclk && !sclk_p) begin
            rise_cnt <= rise_cnt + 1;
            period <= cyc - last_rise;
            last_rise <= cyc;
        end
        if (snap_strb && !cap_p) cap_cnt <= cap_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (!xfer_n) lo_run <= lo_run + 1;
        else begin
            if (lo_run != 0) lo_last <= lo_run;
            lo_run <= 0;
        end
        sclk_p <= sclk;
        cap_p <= snap_strb;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        rise_cnt = 0; cap_cnt = 0; done_cnt = 0;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    // R1: outputs after reset.
    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 sel_n/xfer_n", {sel_n, xfer_n}, 2'b11);
        check("R1 sclk/snap", {sclk, snap_strb}, 2'b00);
    endtask

    // R2 R3 R5 R6 R7 R8: one word with a given load window.
    task automatic t_single(input logic [WORD_W-1:0] w, input logic [LOAD_W-1:0] len);
        bit ok;
        int exp_len;
        exp_len = (len == 0) ? 1 : int'(len);
        status_in = w;
        load_cycles = len;
        pulse_start();
        check("R2 capture strobe after start", snap_strb, 1);
        check("R8 busy after start", busy, 1);
        @(negedge clk);
        check("R2 strobe single, load low", {snap_strb, xfer_n}, 2'b00);
        wait_done(ok);
        check("R8 done seen", ok, 1);
        check("R6 word MSB first", rd_word, w);
        check("R8 busy low at done", busy, 0);
        #1;
        check("R5 sixteen rises", rise_cnt, 16);
        check("R3 load window", lo_last, exp_len);
        check("R7 sclk period", period, 2 * HALF);
        @(negedge clk);
        check("R8 done single pulse", done, 0);
        check("R7 sclk idle low, R4 deselected", {sclk, sel_n}, 2'b01);
    endtask

    // R9: start raised in mid-shift is ignored.
    task automatic t_ignore();
        bit ok;
        status_in = 16'hA5C3;
        load_cycles = 4'd1;
        pulse_start();
        for (int i = 0; i < 12; i++) @(negedge clk);
        req_start = 1'b1;
        status_in = 16'h0F0F;
        @(negedge clk);
        req_start = 1'b0;
        wait_done(ok);
        check("R9 word undisturbed", rd_word, 16'hA5C3);
        for (int i = 0; i < 20; i++) @(negedge clk);
        check("R9 single capture", cap_cnt, 1);
        check("R9 single done", done_cnt, 1);
        check("R9 stays idle", {busy, sel_n}, 2'b01);
    endtask

    // R10: continuous mode, capture during shift, two words, then stop.
    task automatic t_continuous();
        bit ok;
        int guard;
        status_in = 16'h1234;
        load_cycles = 4'd2;
        cont_mode = 1'b1;
        pulse_start();
        status_in = 16'hBEEF;
        guard = 0;
        while (cap_cnt < 2 && guard < 2000) begin @(negedge clk); guard++; end
        status_in = 16'h5555;
        cont_mode = 1'b0;
        wait_done(ok);
        check("R10 first word", rd_word, 16'h1234);
        check("R10 busy held between words", busy, 1);
        @(negedge clk);
        wait_done(ok);
        check("R10 second word from mid-shift capture", rd_word, 16'hBEEF);
        check("R10 busy low at last done", busy, 0);
        for (int i = 0; i < 20; i++) @(negedge clk);
        check("R10 two capture strobes", cap_cnt, 2);
        check("R10 two done pulses", done_cnt, 2);
        check("R10 32 rises", rise_cnt, 32);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single(16'h8001, 4'd3);
        t_single(16'h6C39, 4'd0);
        t_single(16'hFFFE, 4'd15);
        t_ignore();
        t_continuous();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule